// File: doc/BRIEF.md
# Seven-to-one flat-panel pixel serializer

This block turns parallel RGB pixels into serial streams for a flat-panel link. Each pixel carries 8-bit red, green and blue channels plus display-enable, vertical-sync and horizontal-sync. The block spreads each pixel over four data lanes and sends seven bit slots per lane. A clock lane beside the data lanes outputs a fixed 7-slot pattern, so its edges fall on the slot boundaries. Everything runs on the serial bit clock, which runs at seven times the pixel rate. One pixel period is seven cycles of a free-running slot counter. The 7x clock and the pixel timing it implies are produced outside this block.

Pixels enter through a valid/ready stream into a one-word holding register. `in_ready` is high when the holding register is empty. It is also high in the last slot of a pixel, because the held word moves into the lane shift registers on that edge. Otherwise `in_ready` is low, and the upstream source must keep its word and `in_valid` steady until a handshake occurs. If the holding register is empty when a new pixel begins, the block sends a blank pixel: every colour and control bit is zero.

Two static controls are sampled only on the slot-counter wrap edge. `map_sel` chooses between two bit-to-slot assignments. `six_bit` selects reduced-colour operation, in which the fourth lane is switched off. A change to either control mid-pixel never alters the word already on the lanes.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: A slot counter runs 0 to 6 and wraps. On the wrap edge the next word is loaded into the per-lane shift registers. Lane bit `lane_data[i]` then carries that word's slot k during counter value k, first slot at k=0. Lane index 0..3 means lanes A, B, C and D.
- R2: With `map_sel`=1 at the load edge, the slots from first to last are as follows. A: G2 R7 R6 R5 R4 R3 R2. B: B3 B2 G7 G6 G5 G4 G3. C: DE VS HS B7 B6 B5 B4. D: 0 B1 B0 G1 G0 R1 R0.
- R3: With `map_sel`=0 at the load edge, the slots from first to last are as follows. A: G0 R5 R4 R3 R2 R1 R0. B: B1 B0 G5 G4 G3 G2 G1. C: DE VS HS B5 B4 B3 B2. D: 0 B7 B6 G7 G6 R7 R6.
- R4: The first slot of lane D is always 0.
- R5: With `six_bit`=1 at the load edge, `lane_oe[3]` is 0 and `lane_data[3]` is 0 for the whole pixel. `lane_oe[2:0]` stays 3'b111, and lanes A to C keep the R2/R3 mapping. With `six_bit`=0, `lane_oe` is 4'b1111.
- R6: `clk_lane` outputs 1,1,0,0,0,1,1 over slots 0 to 6 of every pixel.
- R7: `map_sel` and `six_bit` take effect only at the load edge. Toggling them mid-pixel changes neither the lanes nor `lane_oe` until the next pixel.
- R8: `in_ready` = 1 when the holding register is empty or the counter is at slot 6, and 0 otherwise. A word accepted with `in_valid`&&`in_ready` appears on the lanes in the pixel after the next wrap edge. A word held under back-pressure is not lost.
- R9: If no word is held at a load edge, the next pixel is blank: all data lanes are 0 and the clock lane runs normally.
- R10: Synchronous reset `rst` clears the slot counter and the held word. During reset all data lanes are 0, `clk_lane` is 1, `in_ready` is 1 and `lane_oe` is 4'b1111. After release the first pixel starts at slot 0 and is blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7x serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel word valid |
| in_ready | output | 1 | Holding register can take a word |
| in_red | input | 8 | Red channel |
| in_green | input | 8 | Green channel |
| in_blue | input | 8 | Blue channel |
| in_de | input | 1 | Display enable |
| in_vsync | input | 1 | Vertical sync |
| in_hsync | input | 1 | Horizontal sync |
| map_sel | input | 1 | Slot mapping select (R2/R3) |
| six_bit | input | 1 | Reduced-colour mode, lane D off |
| lane_data | output | 4 | Serial bits, index 0..3 = lanes A..D |
| lane_oe | output | 4 | Output enable per data lane |
| clk_lane | output | 1 | Clock-lane serial bit |

## Verification
Two events can fall on the same edge at slot 6: the held word moves into the shift registers, and a new word is accepted into the freed holding register. The bench provokes this by presenting a second pixel while the first is still held. It checks that `in_ready` stays low until slot 6 and that both words then appear intact on consecutive pixels, followed by a blank pixel. A second overlap is a mode change arriving in the middle of a pixel whose mapping was already latched. To provoke it, every table vector toggles both controls at slot 3 and checks that the lanes and enables of that pixel still follow the values present at the load edge.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int SLOTS  = 7;
  localparam int LANES  = 4;
  localparam int CW     = 8;
  localparam int SLOT_W = $clog2(SLOTS);

  // clock-lane pattern, bit SLOTS-1 is sent first
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

  typedef struct packed {
    logic [CW-1:0] red;
    logic [CW-1:0] green;
    logic [CW-1:0] blue;
    logic          de;
    logic          vsync;
    logic          hsync;
  } pixel_t;
endpackage

// File: rtl/lvds_slot_counter.sv
module lvds_slot_counter #(
  parameter int SLOTS  = 7,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot_o,
  output logic              wrap_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign slot_o = cnt_q;
  assign wrap_o = (cnt_q == LAST);
endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
  import lvds_ser_pkg::*;
(
  input  pixel_t                       pix,
  input  logic                         map_sel,
  input  logic                         six_bit,
  output logic [LANES-1:0][SLOTS-1:0]  words
);
  logic [SLOTS-1:0] wa, wb, wc, wd;

  // MSB of each word is the first slot on the lane
  always_comb begin
    if (map_sel) begin
      wa = {pix.green[2], pix.red[7:2]};
      wb = {pix.blue[3:2], pix.green[7:3]};
      wc = {pix.de, pix.vsync, pix.hsync, pix.blue[7:4]};
      wd = {1'b0, pix.blue[1:0], pix.green[1:0], pix.red[1:0]};
    end else begin
      wa = {pix.green[0], pix.red[5:0]};
      wb = {pix.blue[1:0], pix.green[5:1]};
      wc = {pix.de, pix.vsync, pix.hsync, pix.blue[5:2]};
      wd = {1'b0, pix.blue[7:6], pix.green[7:6], pix.red[7:6]};
    end
    words = {(six_bit ? {SLOTS{1'b0}} : wd), wc, wb, wa};
  end
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         sout
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)       sr_q <= '0;
    else if (load) sr_q <= din;
    else           sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign sout = sr_q[W-1];
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CW-1:0]    in_red,
  input  logic [CW-1:0]    in_green,
  input  logic [CW-1:0]    in_blue,
  input  logic             in_de,
  input  logic             in_vsync,
  input  logic             in_hsync,
  input  logic             map_sel,
  input  logic             six_bit,
  output logic [LANES-1:0] lane_data,
  output logic [LANES-1:0] lane_oe,
  output logic             clk_lane
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0]            slot_q;
  logic                         wrap;
  logic                         hold_full;
  pixel_t                       hold_q;
  pixel_t                       pix_in;
  pixel_t                       pix_sel;
  logic                         accept;
  logic [LANES-1:0][SLOTS-1:0]  words;

  lvds_slot_counter #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .slot_o (slot_q),
    .wrap_o (wrap)
  );

  assign pix_in   = '{red: in_red, green: in_green, blue: in_blue,
                      de: in_de, vsync: in_vsync, hsync: in_hsync};
  assign in_ready = !hold_full || wrap;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else begin
      if (accept)    hold_q <= pix_in;
      if (accept)    hold_full <= 1'b1;
      else if (wrap) hold_full <= 1'b0;
    end
  end

  // underflow sends a blank word
  assign pix_sel = hold_full ? hold_q : '0;

  lvds_lane_mapper u_map (
    .pix     (pix_sel),
    .map_sel (map_sel),
    .six_bit (six_bit),
    .words   (words)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lvds_lane_shifter #(.W(SLOTS)) u_sh (
      .clk  (clk),
      .rst  (rst),
      .load (wrap),
      .din  (words[g]),
      .sout (lane_data[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)       lane_oe <= '1;
    else if (wrap) lane_oe <= {~six_bit, {(LANES-1){1'b1}}};
  end

  assign clk_lane = CLK_PATTERN[LAST - slot_q];
endmodule

// File: rtl/lvds_pixel_serializer_chk.sv
module lvds_pixel_serializer_chk #(
  parameter int SLOTS  = 7,
  parameter int LANES  = 4,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LANES-1:0]  lane_data,
  input logic [LANES-1:0]  lane_oe,
  input logic              clk_lane,
  input logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] PRE  = SLOT_W'(SLOTS - 2);

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot <= LAST); // R1

  AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (rst)
    (slot == '0) |-> !lane_data[LANES-1]); // R4

  AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lane_oe[LANES-1] |-> !lane_data[LANES-1]); // R5

  AST_CLK_LOW_RUN: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_lane) |=> !clk_lane ##1 !clk_lane ##1 clk_lane); // R6

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (slot != '0) |-> $stable(lane_oe)); // R7

  AST_READY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (slot == LAST) |-> in_ready); // R8

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && slot != PRE) |=> !in_ready); // R8
endmodule

bind lvds_pixel_serializer lvds_pixel_serializer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .lane_data (lane_data),
  .lane_oe   (lane_oe),
  .clk_lane  (clk_lane),
  .slot      (slot_q)
);

// File: tb/lvds_pixel_serializer_test.sv
module lvds_pixel_serializer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_red = '0, in_green = '0, in_blue = '0;
  logic       in_de = 1'b0, in_vsync = 1'b0, in_hsync = 1'b0;
  logic       map_sel = 1'b0, six_bit = 1'b0;
  logic [3:0] lane_data, lane_oe;
  logic       clk_lane;

  int n_tests = 0;
  int n_fail  = 0;
  int tb_slot = 0;

  localparam logic [6:0] CLKP = 7'b1100011;
  // {map, six, red, green, blue, de, vsync, hsync}
  localparam logic [28:0] VEC [6] = '{
    {1'b1, 1'b0, 8'hA5, 8'h3C, 8'hF0, 1'b1, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 1'b1, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'hFF, 8'h00, 8'h81, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h5A, 8'hC3, 8'h0F, 1'b1, 1'b1, 1'b1},
    {1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'h12, 8'hEF, 8'h6B, 1'b0, 1'b0, 1'b1}
  };

  lvds_pixel_serializer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
    .in_de(in_de), .in_vsync(in_vsync), .in_hsync(in_hsync),
    .map_sel(map_sel), .six_bit(six_bit),
    .lane_data(lane_data), .lane_oe(lane_oe), .clk_lane(clk_lane)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tb_slot <= 0;
    else     tb_slot <= (tb_slot == 6) ? 0 : tb_slot + 1;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0][6:0] expect_words(input logic [28:0] v);
    logic m, s, de, vs, hs;
    logic [7:0] r, g, b;
    logic [6:0] la, lb, lc, ld;
    m = v[28]; s = v[27]; r = v[26:19]; g = v[18:11]; b = v[10:3];
    de = v[2]; vs = v[1]; hs = v[0];
    lc = {de, vs, hs, 4'b0000};
    if (m) begin
      la = {g[2], r[7], r[6], r[5], r[4], r[3], r[2]};
      lb = {b[3], b[2], g[7], g[6], g[5], g[4], g[3]};
      lc[3:0] = {b[7], b[6], b[5], b[4]};
      ld = {1'b0, b[1], b[0], g[1], g[0], r[1], r[0]};
    end else begin
      la = {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
      lb = {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
      lc[3:0] = {b[5], b[4], b[3], b[2]};
      ld = {1'b0, b[7], b[6], g[7], g[6], r[7], r[6]};
    end
    if (s) ld = 7'd0;
    return {ld, lc, lb, la};
  endfunction

  task automatic set_pix(input logic [28:0] v);
    map_sel = v[28]; six_bit = v[27];
    in_red = v[26:19]; in_green = v[18:11]; in_blue = v[10:3];
    in_de = v[2]; in_vsync = v[1]; in_hsync = v[0];
  endtask

  task automatic wait_slot(input int s);
    @(negedge clk);
    while (tb_slot != s) @(negedge clk);
  endtask

  // call at the negedge of slot 0; returns at the negedge of slot 6
  task automatic capture(input bit flip, input logic [3:0] oe_exp,
                         output logic [3:0][6:0] w, output int oe_bad,
                         output int clk_bad);
    oe_bad = 0; clk_bad = 0; w = '0;
    for (int s = 0; s < 7; s++) begin
      for (int l = 0; l < 4; l++) w[l][6-s] = lane_data[l];
      if (lane_oe !== oe_exp) oe_bad++;
      if (clk_lane !== CLKP[6-s]) clk_bad++;
      if (flip && s == 3) begin
        map_sel = ~map_sel;
        six_bit = ~six_bit;
      end
      if (s < 6) @(negedge clk);
    end
  endtask

  task automatic check_words(input string tag, input logic [3:0][6:0] got,
                             input logic [3:0][6:0] exp);
    for (int l = 0; l < 4; l++)
      chk($sformatf("%s lane %0d", tag, l), {25'd0, got[l]}, {25'd0, exp[l]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [3:0][6:0] w;
    logic [3:0][6:0] e;
    int ob, cb;

    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 reset lanes zero", {28'd0, lane_data}, 32'd0);
    chk("R10 reset clk lane high", {31'd0, clk_lane}, 32'd1);
    chk("R10 reset ready", {31'd0, in_ready}, 32'd1);
    chk("R10 reset oe", {28'd0, lane_oe}, 32'hF);
    rst = 1'b0;
    // R9 R10 first pixel after release is blank, pattern from slot 0
    capture(1'b0, 4'hF, w, ob, cb);
    check_words("R9 blank after reset", w, '0);
    chk("R6 clock lane after reset", cb, 0);

    // table walk: R1 R2 R3 R4 R5 R7
    for (int i = 0; i < 6; i++) begin
      wait_slot(0);
      set_pix(VEC[i]);
      in_valid = 1'b1;
      chk("R8 ready while empty", {31'd0, in_ready}, 32'd1);
      @(negedge clk);
      in_valid = 1'b0;
      wait_slot(0);
      capture(1'b1, {~VEC[i][27], 3'b111}, w, ob, cb);
      e = expect_words(VEC[i]);
      check_words($sformatf("R2 R3 R4 R5 vec %0d", i), w, e);
      chk($sformatf("R5 R7 oe vec %0d", i), ob, 0);
      chk($sformatf("R6 clock vec %0d", i), cb, 0);
    end

    // R8 back-pressure: load and accept on the same wrap edge
    begin
      int low_bad;
      logic [28:0] p1, p2;
      p1 = {1'b0, 1'b0, 8'h96, 8'h69, 8'hC5, 1'b1, 1'b0, 1'b0};
      p2 = {1'b0, 1'b0, 8'h3E, 8'hD1, 8'h7A, 1'b0, 1'b1, 1'b1};
      low_bad = 0;
      wait_slot(0);
      set_pix(p1);
      in_valid = 1'b1;
      @(negedge clk);
      set_pix(p2);
      while (tb_slot != 6) begin
        if (in_ready !== 1'b0) low_bad++;
        @(negedge clk);
      end
      chk("R8 ready low while full", low_bad, 0);
      chk("R8 ready at slot 6", {31'd0, in_ready}, 32'd1);
      @(negedge clk);
      in_valid = 1'b0;
      capture(1'b0, 4'hF, w, ob, cb);
      check_words("R8 first word", w, expect_words(p1));
      @(negedge clk);
      capture(1'b0, 4'hF, w, ob, cb);
      check_words("R8 stalled word", w, expect_words(p2));
      @(negedge clk);
      capture(1'b0, 4'hF, w, ob, cb);
      check_words("R9 underflow blank", w, '0);
      chk("R6 clock on blank", cb, 0);
    end

    // R10 mid-pixel reset discards held word and restarts slot 0
    wait_slot(0);
    set_pix({1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1});
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    wait_slot(3);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid reset lanes", {28'd0, lane_data}, 32'd0);
    chk("R10 mid reset clk", {31'd0, clk_lane}, 32'd1);
    chk("R10 mid reset oe", {28'd0, lane_oe}, 32'hF);
    map_sel = 1'b0; six_bit = 1'b0;
    rst = 1'b0;
    capture(1'b0, 4'hF, w, ob, cb);
    check_words("R10 held word dropped", w, '0);
    chk("R10 clock restart", cb, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule